// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem control register and the modem status register of a 16550-style serial port. The control register drives four handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs) and carries a loopback enable. The status register tracks four external handshake inputs (clear-to-send, data-set-ready, carrier-detect and ring). Each input passes through a configurable synchroniser. A change on an input latches a sticky delta flag, and a read of the status register clears those flags.

In loopback the status read no longer shows the external lines. It shows the control outputs moved onto the status positions, and the external data-terminal-ready and request-to-send pins keep their last driven values. A single any-delta output feeds the port's interrupt logic. Register accesses are single-cycle strobes. Read data is combinational on the cycle of the strobe.

Top module: `modem_ctl_stat`

## Requirements
- R1: Status read bits 7:4 are the synchronised levels of carrier-detect (7), ring (6), data-set-ready (5) and clear-to-send (4). A change at an input appears there on the third rising edge after it, with two synchroniser stages.
- R2: A level change on carrier-detect, data-set-ready or clear-to-send sets status bit 3, 1 or 0 respectively, on the same edge that the new level reaches bits 7:4.
- R3: Status bit 2 (ring trailing edge) is set only when ring goes from 1 to 0. A rising ring leaves it unchanged.
- R4: A status read outside loopback clears status bits 3:0 on the following edge.
- R5: A control write stores write-data bits 4:0: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 out1, bit 3 out2, bit 4 loopback. The control read returns them with bits 7:5 zero. out1_o and out2_o follow bits 2 and 3 from the edge of the write.
- R6: In loopback a status read returns out2 in bit 7, out1 in bit 6, data-terminal-ready in bit 5 and request-to-send in bit 4, with bits 3:0 zero. Such a read leaves the stored delta flags untouched.
- R7: dtr_o and rts_o take the control bits one edge after the register changes, and only while loopback is off. While it is on, they hold.
- R8: After reset the control read is 0x08, the status read is 0xB0, dtr_o, rts_o, out1_o and delta_any_o are 0, and out2_o is 1.
- R9: delta_any_o is high exactly when at least one of the stored status bits 3:0 is set.
- R10: An input change whose delta would be set on the same edge as a clearing status read sets that delta. The flags present before the read are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data |
| ctl_rdata | output | 8 | Control register read value |
| stat_rd | input | 1 | Status register read strobe (clears deltas) |
| stat_rdata | output | 8 | Status register read value |
| cts_i | input | 1 | Clear-to-send input (asynchronous) |
| dsr_i | input | 1 | Data-set-ready input (asynchronous) |
| dcd_i | input | 1 | Carrier-detect input (asynchronous) |
| ri_i | input | 1 | Ring input (asynchronous) |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |
| delta_any_o | output | 1 | Any status delta flag set |

## Verification
The assertions check four things on every cycle: that the stored input levels track the synchroniser output, that each detected change lands in its delta bit, that a rising ring never sets the trailing-edge flag, and that a clearing read empties the flags when no change coincides with it. They also check that the handshake pins stay put through loopback and that the any-delta output agrees with the read value. Only the bench scenarios can show the end-to-end latency from an asynchronous pin to the read value. The same holds for the exact loopback bit mapping across all control values, a change that collides with a read, and delta flags surviving a read made in loopback.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   localparam int CTRL_W = 5;
   localparam int NIB_W  = 4;
   localparam int REG_W  = 8;

   // nibble positions of the modem inputs (status bits 7:4 / 3:0)
   localparam int IDX_CTS = 0;
   localparam int IDX_DSR = 1;
   localparam int IDX_RI  = 2;
   localparam int IDX_DCD = 3;

   typedef struct packed {
      logic loop;
      logic out2;
      logic out1;
      logic rts;
      logic dtr;
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("mcs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
   import mcs_pkg::*;
#(
   parameter ctrl_t RST_VAL = CTRL_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o
);
   logic dtr_pin_q;
   logic rts_pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= RST_VAL;
      else if (wr) ctrl_q <= ctrl_t'(wdata);
   end

   // handshake pins follow the register only outside loopback
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dtr_pin_q <= 1'b0;
         rts_pin_q <= 1'b0;
      end else if (!ctrl_q.loop) begin
         dtr_pin_q <= ctrl_q.dtr;
         rts_pin_q <= ctrl_q.rts;
      end
   end

   assign dtr_o  = dtr_pin_q;
   assign rts_o  = rts_pin_q;
   assign out1_o = ctrl_q.out1;
   assign out2_o = ctrl_q.out2;
endmodule

// File: rtl/mcs_stat.sv
module mcs_stat
   import mcs_pkg::*;
#(
   parameter logic [NIB_W-1:0] RST_LVL = 4'b1011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] lvl,
   input  logic             clr,
   output logic [NIB_W-1:0] hi_q,
   output logic [NIB_W-1:0] delta_q
);
   logic [NIB_W-1:0] diff;
   logic [NIB_W-1:0] hit;

   assign diff = lvl ^ hi_q;

   for (genvar b = 0; b < NIB_W; b++) begin : g_hit
      if (b == IDX_RI) begin : g_trail
         assign hit[b] = hi_q[b] & ~lvl[b];
      end else begin : g_edge
         assign hit[b] = diff[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= RST_LVL;
         delta_q <= '0;
      end else begin
         hi_q    <= lvl;
         delta_q <= (clr ? '0 : delta_q) | hit;
      end
   end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
   import mcs_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [NIB_W-1:0] RST_LVL     = 4'b1011,
   parameter ctrl_t            RST_CTRL    = CTRL_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTRL_W-1:0] ctl_wdata,
   output logic [REG_W-1:0]  ctl_rdata,
   input  logic              stat_rd,
   output logic [REG_W-1:0]  stat_rdata,
   input  logic              cts_i,
   input  logic              dsr_i,
   input  logic              dcd_i,
   input  logic              ri_i,
   output logic              dtr_o,
   output logic              rts_o,
   output logic              out1_o,
   output logic              out2_o,
   output logic              delta_any_o
);
   localparam int PAD_W = REG_W - CTRL_W;

   logic [NIB_W-1:0] raw_lvl;
   logic [NIB_W-1:0] sync_lvl;
   logic [NIB_W-1:0] stat_hi;
   logic [NIB_W-1:0] delta_q;
   ctrl_t            ctrl_q;
   logic             ctrl_loop;
   logic             rd_clr;

   always_comb begin
      raw_lvl          = '0;
      raw_lvl[IDX_CTS] = cts_i;
      raw_lvl[IDX_DSR] = dsr_i;
      raw_lvl[IDX_RI]  = ri_i;
      raw_lvl[IDX_DCD] = dcd_i;
   end

   mcs_sync #(.WIDTH(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL(RST_LVL)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (raw_lvl),
      .q (sync_lvl)
   );

   mcs_ctrl #(.RST_VAL(RST_CTRL)) u_ctrl (
      .clk (clk),
      .rst_n (rst_n),
      .wr (ctl_wr),
      .wdata (ctl_wdata),
      .ctrl_q (ctrl_q),
      .dtr_o (dtr_o),
      .rts_o (rts_o),
      .out1_o (out1_o),
      .out2_o (out2_o)
   );

   assign ctrl_loop = ctrl_q.loop;
   assign rd_clr    = stat_rd & ~ctrl_loop;

   mcs_stat #(.RST_LVL(RST_LVL)) u_stat (
      .clk (clk),
      .rst_n (rst_n),
      .lvl (sync_lvl),
      .clr (rd_clr),
      .hi_q (stat_hi),
      .delta_q (delta_q)
   );

   assign ctl_rdata = {{PAD_W{1'b0}}, ctrl_q};

   always_comb begin
      if (ctrl_loop)
         stat_rdata = {ctrl_q.out2, ctrl_q.out1, ctrl_q.dtr, ctrl_q.rts, {NIB_W{1'b0}}};
      else
         stat_rdata = {stat_hi, delta_q};
   end

   assign delta_any_o = |delta_q;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       stat_rd,
   input logic [3:0] sync_lvl,
   input logic [3:0] hi,
   input logic [3:0] delta,
   input logic       loop,
   input logic       dtr_o,
   input logic       rts_o,
   input logic       delta_any_o,
   input logic [7:0] stat_rdata
);
   p_level_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> hi == $past(sync_lvl));

   p_delta_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (((sync_lvl ^ hi) & 4'b1011) != 4'b0000)
      |=> ((delta & $past((sync_lvl ^ hi) & 4'b1011)) == $past((sync_lvl ^ hi) & 4'b1011)));

   p_ri_rise_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !hi[2] && sync_lvl[2]) |=> delta[2] == $past(delta[2]));

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !loop && (sync_lvl == hi)) |=> delta == 4'b0000);

   p_loop_pins_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loop |=> ($stable(dtr_o) && $stable(rts_o)));

   p_any_delta_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop) |-> (delta_any_o == (stat_rdata[3:0] != 4'b0000)));
endmodule

bind modem_ctl_stat mcs_checker u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .stat_rd (stat_rd),
   .sync_lvl (sync_lvl),
   .hi (stat_hi),
   .delta (delta_q),
   .loop (ctrl_loop),
   .dtr_o (dtr_o),
   .rts_o (rts_o),
   .delta_any_o (delta_any_o),
   .stat_rdata (stat_rdata)
);

// File: tb/tb_modem_ctl_stat.sv
module tb_modem_ctl_stat;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic [7:0] ctl_rdata;
   logic       stat_rd = 1'b0;
   logic [7:0] stat_rdata;
   logic       cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
   logic       dtr_o, rts_o, out1_o, out2_o, delta_any_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   modem_ctl_stat dut (.*);

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // nibble {dcd,ri,dsr,cts}
   task automatic set_in(input logic [3:0] v);
      dcd_i = v[3]; ri_i = v[2]; dsr_i = v[1]; cts_i = v[0];
   endtask

   task automatic wr_ctl(input logic [4:0] v);
      ctl_wdata = v; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic rd_stat();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   initial begin
      logic dtr_e, rts_e;
      repeat (3) @(negedge clk);
      // R8 reset values
      check("R8 ctl", ctl_rdata, 8'h08);
      check("R8 stat", stat_rdata, 8'hB0);
      check("R8 pins", {3'b0, dtr_o, rts_o, out1_o, out2_o, delta_any_o}, 8'h02);
      rst_n = 1'b1;
      @(negedge clk);

      // R5/R6/R7 sweep of every control value
      dtr_e = 1'b0; rts_e = 1'b0;
      for (int v = 0; v < 32; v++) begin
         wr_ctl(v[4:0]);
         check("R5 rdata", ctl_rdata, {3'b0, v[4:0]});
         check("R5 out12", {6'b0, out2_o, out1_o}, {6'b0, v[3], v[2]});
         if (v[4]) check("R6 loop read", stat_rdata, {v[3], v[2], v[0], v[1], 4'b0});
         @(negedge clk);
         if (!v[4]) begin dtr_e = v[0]; rts_e = v[1]; end
         check("R7 pins", {6'b0, dtr_o, rts_o}, {6'b0, dtr_e, rts_e});
      end
      wr_ctl(5'b01000);
      @(negedge clk);

      // R1/R2/R3/R4/R9 all input transitions
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            logic [3:0] d;
            set_in(a[3:0]);
            repeat (4) @(negedge clk);
            rd_stat();
            check("R4 cleared", {4'b0, stat_rdata[3:0]}, 8'h00);
            set_in(b[3:0]);
            repeat (2) @(negedge clk);
            check("R1 latency", stat_rdata, {a[3:0], 4'b0});
            @(negedge clk);
            d = a[3:0] ^ b[3:0];
            d[2] = a[2] & ~b[2];
            check("R1 R2 R3 status", stat_rdata, {b[3:0], d});
            check("R9 any", {7'b0, delta_any_o}, {7'b0, d != 4'b0});
         end
      end

      // R10 change colliding with a clearing read
      set_in(4'b1011);
      repeat (4) @(negedge clk);
      rd_stat();
      set_in(4'b1010);              // cts falls
      repeat (4) @(negedge clk);
      check("R10 pre", stat_rdata, 8'hA1);
      set_in(4'b1000);              // dsr falls
      repeat (2) @(negedge clk);
      rd_stat();                    // read edge = delta edge
      check("R10 collide", stat_rdata, 8'h82);

      // R6 loop read keeps deltas
      wr_ctl(5'b11000);
      rd_stat();
      check("R6 loop no clear", stat_rdata, 8'h80);
      wr_ctl(5'b01000);
      check("R6 delta kept", stat_rdata, 8'h82);
      rd_stat();
      check("R4 final clear", stat_rdata, 8'h80);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule